// File: doc/BRIEF.md
# Selectable Clock Divider with Odd-Modulus Duty Correction

This block divides a fast source clock by a selectable integer modulus. It keeps the output near a 50% duty cycle for both even and odd moduli. A binary select code is captured on a load strobe. Each nonzero code maps to a modulus through a fixed mapping function in the package. In this build the modulus equals the code value, so a 4-bit code gives moduli 1 to 15. Code 0 turns the output off and parks it low, so it stops switching.

A counter running on the rising edge produces the primary waveform. It holds the output high for the first floor(N/2) source cycles of each N-cycle period. For odd N, a second flop copies that waveform on the falling edge, and the two are ORed. This stretches the high phase by half a source period, so high and low each last N/2 source periods. Modulus 1 routes the source clock straight to the output through a selector that switches only while the source clock is low.

A newly loaded code waits in a pending register. It takes effect only at the end of the current output period, or on the next rising edge while the output is off. The counter restarts at that point, so every period begins with a complete high phase.

Top module: `clkdiv_duty`

## Requirements
- R1: While rst_n is low, clk_out and out_en are 0 and the divider is off.
- R2: sel_code is captured only on a rising edge where sel_load is 1. Changes on sel_code with sel_load at 0 do not alter clk_out or out_en.
- R3: The modulus equals the captured code value. Code 0 disables the divider: clk_out stays low and out_en is 0.
- R4: For an even modulus N, each output period lasts N source cycles. The output is high for the first N/2 cycles and low for the rest.
- R5: For an odd modulus N of 3 or more, each period lasts N source cycles. The output is high for exactly N source half-periods from the period start, then low for N half-periods.
- R6: For modulus 1, clk_out follows the source clock: high in its high half and low in its low half.
- R7: A captured code is applied only at a rising edge that ends the current output period. While disabled, it is applied at the next rising edge. out_en changes at that same edge.
- R8: A sel_load in the last source cycle of a period makes the new code take effect at the edge that ends that period.
- R9: Whenever a new setting is applied, the next period starts with the full high phase of the new modulus at that edge.
- R10: When modulus 1 is replaced by code 0, clk_out completes one last high half-period of the source clock and then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | SEL_W | Select code (0 = off, otherwise the modulus) |
| sel_load | input | 1 | Capture strobe for sel_code, sampled on the rising edge |
| clk_out | output | 1 | Divided, duty-corrected clock |
| out_en | output | 1 | High while a nonzero modulus is active |

## Verification
Two events can fall on the same rising edge: a fresh capture strobe and the end of an output period. The design must then take the strobed code at once, not the previously pending one. The bench tracks its own period position and provokes this by strobing exactly in the last cycle of a period. It also strobes mid-period, where the old waveform must run to completion. In both cases a scoreboard judges every source half-period of clk_out against a half-slot model, in which slot h of a period is high when h is below the modulus.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Fixed code-to-modulus mapping: every nonzero code selects the modulus of equal value.
  function automatic int unsigned code_to_mod(input int unsigned code);
    return code;
  endfunction

  // Rising-edge cycles with the primary waveform high: floor(N/2).
  function automatic int unsigned high_cycles(input int unsigned n);
    return n / 2;
  endfunction

  // Moduli that need the falling-edge half-period extension.
  function automatic bit needs_half(input int unsigned n);
    return (n >= 3) && (n % 2 == 1);
  endfunction

endpackage

// File: rtl/clkdiv_sel_stage.sv
`timescale 1ns/1ps
module clkdiv_sel_stage #(
  parameter int SEL_W = 4,
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             sel_load,
  input  logic             last_cyc,
  output logic [MOD_W-1:0] act_mod,
  output logic [MOD_W-1:0] nxt_mod,
  output logic             bnd
);
  import clkdiv_pkg::*;

  logic [SEL_W-1:0] pend_q;
  logic [SEL_W-1:0] pend_nxt;
  logic [MOD_W-1:0] pend_mod;

  // A strobe in the boundary cycle bypasses the pending register.
  assign pend_nxt = sel_load ? sel_code : pend_q;
  assign pend_mod = MOD_W'(code_to_mod(int'(pend_nxt)));
  assign bnd      = (act_mod == '0) || last_cyc;
  assign nxt_mod  = bnd ? pend_mod : act_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_mod <= '0;
    end else begin
      pend_q  <= pend_nxt;
      act_mod <= nxt_mod;
    end
  end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] act_mod,
  input  logic [MOD_W-1:0] nxt_mod,
  input  logic             bnd,
  output logic [MOD_W-1:0] cnt,
  output logic             last_cyc,
  output logic             q_pos
);
  import clkdiv_pkg::*;

  logic [MOD_W-1:0] cnt_nxt;
  logic             q_pos_nxt;

  assign last_cyc = (act_mod != '0) && (cnt == act_mod - MOD_W'(1));
  assign cnt_nxt  = bnd ? '0 : cnt + MOD_W'(1);

  always_comb begin
    if (nxt_mod == '0)
      q_pos_nxt = 1'b0;
    else if (nxt_mod == MOD_W'(1))
      q_pos_nxt = 1'b1;
    else
      q_pos_nxt = int'(cnt_nxt) < int'(high_cycles(int'(nxt_mod)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      q_pos <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      q_pos <= q_pos_nxt;
    end
  end
endmodule

// File: rtl/clkdiv_duty_fix.sv
`timescale 1ns/1ps
module clkdiv_duty_fix #(
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] act_mod,
  input  logic             q_pos,
  output logic             q_neg,
  output logic             byp,
  output logic             clk_out
);
  import clkdiv_pkg::*;

  logic odd_act;
  assign odd_act = needs_half(int'(act_mod));

  // Falling-edge copy adds half a source period to odd-modulus high phases;
  // the pass-through selector also changes only while the source is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_neg <= 1'b0;
      byp   <= 1'b0;
    end else begin
      q_neg <= q_pos & odd_act;
      byp   <= (act_mod == MOD_W'(1));
    end
  end

  assign clk_out = byp ? clk : (q_pos | q_neg);
endmodule

// File: rtl/clkdiv_duty.sv
`timescale 1ns/1ps
module clkdiv_duty #(
  parameter int SEL_W = 4
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             sel_load,
  output logic             clk_out,
  output logic             out_en
);
  localparam int MOD_W = SEL_W;

  logic [MOD_W-1:0] act_mod;
  logic [MOD_W-1:0] nxt_mod;
  logic [MOD_W-1:0] cnt;
  logic             bnd;
  logic             last_cyc;
  logic             q_pos;
  logic             q_neg;
  logic             byp;

  clkdiv_sel_stage #(.SEL_W(SEL_W), .MOD_W(MOD_W)) sel_i (
    .clk(clk_fast), .rst_n(rst_n), .sel_code(sel_code), .sel_load(sel_load),
    .last_cyc(last_cyc), .act_mod(act_mod), .nxt_mod(nxt_mod), .bnd(bnd)
  );

  clkdiv_counter #(.MOD_W(MOD_W)) cnt_i (
    .clk(clk_fast), .rst_n(rst_n), .act_mod(act_mod), .nxt_mod(nxt_mod),
    .bnd(bnd), .cnt(cnt), .last_cyc(last_cyc), .q_pos(q_pos)
  );

  clkdiv_duty_fix #(.MOD_W(MOD_W)) fix_i (
    .clk(clk_fast), .rst_n(rst_n), .act_mod(act_mod), .q_pos(q_pos),
    .q_neg(q_neg), .byp(byp), .clk_out(clk_out)
  );

  assign out_en = (act_mod != '0);
endmodule

// File: rtl/clkdiv_duty_chk.sv
`timescale 1ns/1ps
module clkdiv_duty_chk #(
  parameter int MOD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MOD_W-1:0] act_mod,
  input logic [MOD_W-1:0] cnt,
  input logic             bnd,
  input logic             q_pos,
  input logic             q_neg
);
  // R4: the period counter never leaves 0..N-1
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod != '0) |-> (cnt < act_mod));

  // R7: the active modulus changes only at a period boundary
  assert_apply_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod != $past(act_mod)) |-> $past(bnd));

  // R9: every boundary restarts the period count
  assert_restart_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (cnt == '0));

  // R3: both waveform flops stay low while disabled
  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod == '0) |-> (!q_pos && !q_neg));

  // R4: no falling-edge extension with an even modulus
  assert_no_ext_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_mod[0]) |-> !q_neg);

  // R6: pass-through keeps the primary flop high and the extension off
  assert_pass_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod == MOD_W'(1)) |-> (q_pos && !q_neg));
endmodule

bind clkdiv_duty clkdiv_duty_chk #(.MOD_W(MOD_W)) chk_i (
  .clk(clk_fast), .rst_n(rst_n), .act_mod(act_mod), .cnt(cnt),
  .bnd(bnd), .q_pos(q_pos), .q_neg(q_neg)
);

// File: tb/clkdiv_duty_tb.sv
`timescale 1ns/1ps
module clkdiv_duty_tb_top;
  localparam int SEL_W      = 4;
  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEL_W-1:0] sel_code = '0;
  logic             sel_load = 1'b0;
  logic             clk_out;
  logic             out_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_duty #(.SEL_W(SEL_W)) dut_i (
    .clk_fast(clk), .rst_n(rst_n), .sel_code(sel_code), .sel_load(sel_load),
    .clk_out(clk_out), .out_en(out_en)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit [1:0] exp_q[$];
  string    tag_q[$];
  string    cur_tag = "R1";

  // bench half-slot model
  int m_pend = 0;
  int m_act  = 0;
  int m_pos  = 0;

  task automatic judge(input bit [1:0] got, input bit [1:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: clk_out,out_en = %b%b expected %b%b",
               tag, $time, got[1], got[0], exp[1], exp[0]);
    end
  endtask

  // driver: one source cycle; pushes the two expected half-slots
  task automatic step(input bit ld, input int code);
    int  pn, prev;
    bit  b, h0, h1, en;
    @(negedge clk);
    sel_load = ld;
    sel_code = code[SEL_W-1:0];
    @(posedge clk);
    pn = ld ? code : m_pend;
    m_pend = pn;
    prev = m_act;
    b = (m_act == 0) || (m_pos == m_act - 1);
    if (b) begin m_act = pn; m_pos = 0; end
    else m_pos++;
    h0 = (2*m_pos)     < m_act;
    h1 = (2*m_pos + 1) < m_act;
    if (b && prev == 1 && m_act == 0) h0 = 1'b1;  // R10 last high half
    en = (m_act != 0);
    exp_q.push_back({h0, en}); tag_q.push_back(cur_tag);
    exp_q.push_back({h1, en}); tag_q.push_back(cur_tag);
  endtask

  task automatic idle(input int n, input int code);
    for (int i = 0; i < n; i++) step(1'b0, code);
  endtask

  task automatic to_last_cycle();
    while (!(m_act != 0 && m_pos == m_act - 1)) step(1'b0, 0);
  endtask

  // monitor: samples each half-period away from the edges
  always begin
    @(posedge clk); #QTR;
    if (exp_q.size() > 0) judge({clk_out, out_en}, exp_q.pop_front(), tag_q.pop_front());
    @(negedge clk); #QTR;
    if (exp_q.size() > 0) judge({clk_out, out_en}, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #QTR;
    judge({clk_out, out_en}, 2'b00, "R1");
    @(posedge clk); #QTR;
    judge({clk_out, out_en}, 2'b00, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R3";  idle(4, 0);          // nothing loaded: off
    cur_tag = "R2";  idle(3, 9);          // code without strobe ignored
    cur_tag = "R4";  step(1'b1, 4); idle(15, 6);
    cur_tag = "R2";  idle(6, 11);         // still modulus 4
    cur_tag = "R7";  step(1'b1, 5); idle(22, 0);
    cur_tag = "R5";  to_last_cycle(); step(1'b1, 7); idle(20, 0);
    cur_tag = "R5";  step(1'b1, 15); idle(40, 0);
    cur_tag = "R3";  step(1'b1, 0); idle(18, 0);
    cur_tag = "R9";  step(1'b1, 3); idle(12, 0);
    cur_tag = "R6";  to_last_cycle(); step(1'b1, 1); idle(6, 0);
    cur_tag = "R10"; step(1'b1, 0); idle(4, 0);
    cur_tag = "R6";  step(1'b1, 1); idle(3, 0);
    cur_tag = "R9";  step(1'b1, 3); idle(8, 0);
    cur_tag = "R8";  to_last_cycle(); step(1'b1, 2); idle(8, 0);
    cur_tag = "R4";  step(1'b1, 14); idle(30, 0);
    cur_tag = "R8";  to_last_cycle(); step(1'b1, 9); idle(20, 0);
    cur_tag = "R7";  step(1'b1, 6); step(1'b1, 2); idle(16, 0);
    cur_tag = "R3";  step(1'b1, 0); idle(6, 0);

    @(posedge clk); @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule